// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder with Reverse Subtract

This unit takes two 32-bit single-precision words, as they would come from general-purpose registers, and returns one 32-bit word. It can form the sum A + B or the reverse difference B − A. A reverse difference flips the sign of A and then adds. Each operand is sorted into one of four classes: zero, finite, infinity or NaN. Finite operands are aligned on the larger exponent, combined, renormalized and rounded to nearest with ties to even. Subnormal inputs and subnormal results are handled in full.

Operations enter and leave through valid/ready streams, and a two-register pipeline sits between them. An input word is taken on a rising edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. Results leave in the order their operations came in. When the output is not taken, the output word stays held and the pipeline behind it fills. With one operation waiting in the middle register and one held at the output, `in_ready` falls until the consumer takes the result. While the output stage is empty, the block accepts one operation per cycle.

Top module: `fpadd_core`

## Requirements
- R1: Words use sign in bit 31, exponent field in bits 30..23 and fraction in bits 22..0. For finite operands with exponent fields 1 to 254, `in_op`=0 returns A + B correctly rounded, including results left after heavy cancellation.
- R2: `in_op`=1 returns B − A, which is B plus A with the sign bit of A inverted.
- R3: If any operand is NaN (exponent field 255, fraction not zero), or the effective operation adds infinities of opposite sign, the result is exactly 0x7FC00000. No other NaN pattern ever appears on the output.
- R4: An infinity (exponent field 255, fraction zero) combined with a finite value or zero returns that infinity, with the sign it has after the operation. Two infinities of the same effective sign return that infinity.
- R5: An operand with exponent field 0 has the value 2^-126 × 0.fraction. Results smaller than 2^-126 come out with exponent field 0, and a subnormal sum that reaches 2^-126 comes out as the smallest normal number.
- R6: Rounding picks the nearest representable value. On an exact tie it picks the candidate whose fraction LSB is 0.
- R7: A result whose rounded exponent reaches 255 becomes infinity (fraction 0) with the sign of the exact result.
- R8: Subtracting equal magnitudes gives +0 (0x00000000). (−0) + (−0) gives −0 (0x80000000), and (+0) + (−0) gives +0.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1. While `out_valid` is 0, `in_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_result` hold on the next cycle.
- R10: If an operation is accepted on edge k while the output stage is free, `out_valid` rises on edge k+1. `out_valid` never rises without an operation accepted two edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair and operation are presented |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 1 | 0 = A + B, 1 = B − A |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| out_valid | output | 1 | Result word is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Result word |

## Verification
Two cases are the hardest to reach from the ports. The first is a tie that lands exactly on the boundary above the largest finite number. The addend must sit exactly one half-ulp below the leading bit, so that round-to-even carries the packed exponent into 255. The stimulus pairs 0x7F7FFFFF with 2^103 to hit this. The second is the back-pressure state where both pipeline registers are full. The bench holds `out_ready` low across two back-to-back accepts, checks that `in_ready` drops and that the held result does not move, then releases the consumer and checks the ordering.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO   = 2'd0,
    CLS_FINITE = 2'd1,
    CLS_INF    = 2'd2,
    CLS_NAN    = 2'd3
  } fp_class_e;

  typedef enum logic {
    OP_ADD  = 1'b0,
    OP_RSUB = 1'b1
  } fp_op_e;

  // Number of guard/round/sticky positions kept below the significand
  localparam int GRS_W = 3;

endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic              flip_sign,
  output logic              sign,
  output fp_class_e         cls,
  output logic [EXP_W-1:0]  exp_eff,
  output logic [FRAC_W:0]   mant
);

  logic [EXP_W-1:0]  efield;
  logic [FRAC_W-1:0] ffield;
  logic              e_max, e_min;

  assign efield = word[WORD_W-2:FRAC_W];
  assign ffield = word[FRAC_W-1:0];
  assign e_max  = &efield;
  assign e_min  = ~|efield;
  assign sign   = word[WORD_W-1] ^ flip_sign;

  always_comb begin
    if (e_max)
      cls = (|ffield) ? CLS_NAN : CLS_INF;
    else if (e_min && ~|ffield)
      cls = CLS_ZERO;
    else
      cls = CLS_FINITE;
  end

  // Subnormals share the scale of exponent field 1 and carry no hidden one
  assign exp_eff = e_min ? EXP_W'(1) : efield;
  assign mant    = {~e_min, ffield};

endmodule

// File: rtl/fpadd_align_add.sv
module fpadd_align_add
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int EXT_W  = FRAC_W + 1 + GRS_W
) (
  input  logic              x_sign,
  input  fp_class_e         x_cls,
  input  logic [EXP_W-1:0]  x_exp,
  input  logic [FRAC_W:0]   x_mant,
  input  logic              y_sign,
  input  fp_class_e         y_cls,
  input  logic [EXP_W-1:0]  y_exp,
  input  logic [FRAC_W:0]   y_mant,
  output logic              special,
  output logic [WORD_W-1:0] special_word,
  output logic              res_sign,
  output logic [EXP_W-1:0]  res_exp,
  output logic [EXT_W:0]    sum
);

  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic [WORD_W-1:0] inf_word(input logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  // Class-driven results that bypass the datapath
  always_comb begin
    special      = 1'b1;
    special_word = QNAN;
    if (x_cls == CLS_NAN || y_cls == CLS_NAN)
      special_word = QNAN;
    else if (x_cls == CLS_INF && y_cls == CLS_INF)
      special_word = (x_sign != y_sign) ? QNAN : inf_word(x_sign);
    else if (x_cls == CLS_INF)
      special_word = inf_word(x_sign);
    else if (y_cls == CLS_INF)
      special_word = inf_word(y_sign);
    else if (x_cls == CLS_ZERO && y_cls == CLS_ZERO)
      special_word = {x_sign & y_sign, {(WORD_W-1){1'b0}}};
    else
      special = 1'b0;
  end

  // Order operands by magnitude
  logic              x_big;
  logic              l_sign, s_sign;
  logic [EXP_W-1:0]  l_exp, s_exp, diff;
  logic [FRAC_W:0]   l_mant, s_mant;

  assign x_big  = {x_exp, x_mant} >= {y_exp, y_mant};
  assign l_sign = x_big ? x_sign : y_sign;
  assign s_sign = x_big ? y_sign : x_sign;
  assign l_exp  = x_big ? x_exp  : y_exp;
  assign s_exp  = x_big ? y_exp  : x_exp;
  assign l_mant = x_big ? x_mant : y_mant;
  assign s_mant = x_big ? y_mant : x_mant;
  assign diff   = l_exp - s_exp;

  // Alignment shift of the smaller operand, collapsing lost bits into sticky
  logic [EXT_W-1:0] ext_l, ext_s, shifted, aligned;
  logic             sticky;

  assign ext_l   = {l_mant, {GRS_W{1'b0}}};
  assign ext_s   = {s_mant, {GRS_W{1'b0}}};
  assign shifted = ext_s >> diff;

  always_comb begin
    sticky = 1'b0;
    for (int i = 0; i < EXT_W; i++)
      if (i < int'(diff)) sticky = sticky | ext_s[i];
  end

  assign aligned = {shifted[EXT_W-1:1], shifted[0] | sticky};

  always_comb begin
    if (l_sign != s_sign)
      sum = {1'b0, ext_l} - {1'b0, aligned};
    else
      sum = {1'b0, ext_l} + {1'b0, aligned};
  end

  assign res_sign = l_sign;
  assign res_exp  = l_exp;

endmodule

// File: rtl/fpadd_norm_round.sv
module fpadd_norm_round
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int EXT_W  = FRAC_W + 1 + GRS_W,
  localparam int XE_W   = EXP_W + 2
) (
  input  logic              special,
  input  logic [WORD_W-1:0] special_word,
  input  logic              sign,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic [EXT_W:0]    sum,
  output logic [WORD_W-1:0] result
);

  localparam logic [XE_W-1:0] EXP_TOP = XE_W'({EXP_W{1'b1}});

  // Leading zeros below the carry position
  int lz;
  always_comb begin
    lz = EXT_W;
    for (int i = 0; i < EXT_W; i++)
      if (sum[i]) lz = EXT_W - 1 - i;
  end

  // Left shift limited so the exponent never drops below the subnormal scale
  int lim, sh;
  assign lim = int'(exp_in) - 1;
  assign sh  = (lz < lim) ? lz : lim;

  logic [EXT_W-1:0] norm;
  logic [XE_W-1:0]  e_norm;

  always_comb begin
    if (sum[EXT_W]) begin
      norm   = {sum[EXT_W:2], sum[1] | sum[0]};
      e_norm = {2'b00, exp_in} + XE_W'(1);
    end else begin
      norm   = sum[EXT_W-1:0] << sh;
      e_norm = {2'b00, exp_in} - XE_W'(sh);
    end
  end

  logic                    hidden, lsb, g_bit, r_bit, s_bit, rnd_up;
  logic [EXP_W-1:0]        e_field;
  logic [EXP_W+FRAC_W-1:0] body;

  assign hidden  = norm[EXT_W-1];
  assign lsb     = norm[GRS_W];
  assign g_bit   = norm[2];
  assign r_bit   = norm[1];
  assign s_bit   = norm[0];
  assign rnd_up  = g_bit & (r_bit | s_bit | lsb);
  assign e_field = hidden ? e_norm[EXP_W-1:0] : '0;
  // A fraction carry walks into the exponent field; from 254 it lands on infinity
  assign body    = {e_field, norm[EXT_W-2:GRS_W]} + (EXP_W+FRAC_W)'(rnd_up);

  always_comb begin
    if (special)
      result = special_word;
    else if (sum == '0)
      result = '0;
    else if (e_norm >= EXP_TOP)
      result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      result = {sign, body};
  end

endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int EXT_W  = FRAC_W + 1 + GRS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_op,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result
);

  // Operand X is the term whose sign is kept, Y the possibly negated term
  logic              rsub;
  logic [WORD_W-1:0] x_word, y_word;
  assign rsub   = (fp_op_e'(in_op) == OP_RSUB);
  assign x_word = rsub ? in_b : in_a;
  assign y_word = rsub ? in_a : in_b;

  logic              x_sign, y_sign;
  fp_class_e         x_cls, y_cls;
  logic [EXP_W-1:0]  x_exp, y_exp;
  logic [FRAC_W:0]   x_mant, y_mant;

  fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_x (
    .word(x_word), .flip_sign(1'b0),
    .sign(x_sign), .cls(x_cls), .exp_eff(x_exp), .mant(x_mant)
  );

  fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_y (
    .word(y_word), .flip_sign(rsub),
    .sign(y_sign), .cls(y_cls), .exp_eff(y_exp), .mant(y_mant)
  );

  logic              a_special, a_sign;
  logic [WORD_W-1:0] a_special_word;
  logic [EXP_W-1:0]  a_exp;
  logic [EXT_W:0]    a_sum;

  fpadd_align_add #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align_add (
    .x_sign(x_sign), .x_cls(x_cls), .x_exp(x_exp), .x_mant(x_mant),
    .y_sign(y_sign), .y_cls(y_cls), .y_exp(y_exp), .y_mant(y_mant),
    .special(a_special), .special_word(a_special_word),
    .res_sign(a_sign), .res_exp(a_exp), .sum(a_sum)
  );

  // Stage 1 register: aligned sum
  logic              s1_valid, s1_special, s1_sign;
  logic [WORD_W-1:0] s1_special_word;
  logic [EXP_W-1:0]  s1_exp;
  logic [EXT_W:0]    s1_sum;

  // Stage 2 register: packed result
  logic              s2_valid;
  logic [WORD_W-1:0] s2_result, n_result;

  logic s2_load, s1_load;
  assign s2_load  = ~s2_valid | out_ready;
  assign s1_load  = ~s1_valid | s2_load;
  assign in_ready = s1_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid        <= 1'b0;
      s1_special      <= 1'b0;
      s1_sign         <= 1'b0;
      s1_special_word <= '0;
      s1_exp          <= '0;
      s1_sum          <= '0;
    end else if (s1_load) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_special      <= a_special;
        s1_sign         <= a_sign;
        s1_special_word <= a_special_word;
        s1_exp          <= a_exp;
        s1_sum          <= a_sum;
      end
    end
  end

  fpadd_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm_round (
    .special(s1_special), .special_word(s1_special_word),
    .sign(s1_sign), .exp_in(s1_exp), .sum(s1_sum), .result(n_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid  <= 1'b0;
      s2_result <= '0;
    end else if (s2_load) begin
      s2_valid <= s1_valid;
      if (s1_valid) s2_result <= n_result;
    end
  end

  assign out_valid  = s2_valid;
  assign out_result = s2_result;

endmodule

// File: rtl/fpadd_core_chk.sv
module fpadd_core_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_result
);

  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result))); // R9

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R9

  AST_NAN_CANONICAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&out_result[WORD_W-2:FRAC_W]) && (|out_result[FRAC_W-1:0]))
      |-> (out_result == QNAN)); // R3

  AST_RISE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2)); // R10

endmodule

bind fpadd_core fpadd_core_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
);

// File: tb/fpadd_core_tb.sv
module fpadd_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_op = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  fpadd_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result)
  );

  // {req[3:0], op, a, b, expected}
  localparam int NV = 23;
  localparam logic [100:0] VEC [NV] = '{
    {4'd1, 1'b0, 32'h3F800000, 32'h3F800000, 32'h40000000}, // R1 1+1
    {4'd1, 1'b0, 32'h3FC00000, 32'h40100000, 32'h40700000}, // R1 1.5+2.25
    {4'd1, 1'b0, 32'h3F800001, 32'hBF800000, 32'h34000000}, // R1 cancellation
    {4'd2, 1'b1, 32'h3F800000, 32'h40400000, 32'h40000000}, // R2 3-1
    {4'd2, 1'b1, 32'h40400000, 32'h3F800000, 32'hC0000000}, // R2 1-3
    {4'd2, 1'b1, 32'hBF800000, 32'h40000000, 32'h40400000}, // R2 2-(-1)
    {4'd8, 1'b0, 32'h3F800000, 32'hBF800000, 32'h00000000}, // R8 x-x
    {4'd8, 1'b0, 32'h80000000, 32'h80000000, 32'h80000000}, // R8 -0+-0
    {4'd8, 1'b0, 32'h00000000, 32'h80000000, 32'h00000000}, // R8 +0+-0
    {4'd3, 1'b0, 32'h7F800001, 32'h3F800000, 32'h7FC00000}, // R3 NaN in
    {4'd3, 1'b0, 32'h7F800000, 32'hFF800000, 32'h7FC00000}, // R3 inf-inf
    {4'd3, 1'b1, 32'h7F800000, 32'h7F800000, 32'h7FC00000}, // R3 rsub inf-inf
    {4'd4, 1'b0, 32'h7F800000, 32'h3F800000, 32'h7F800000}, // R4 inf+1
    {4'd4, 1'b1, 32'h7F800000, 32'h3F800000, 32'hFF800000}, // R4 1-inf
    {4'd5, 1'b0, 32'h00000001, 32'h00000001, 32'h00000002}, // R5 sub+sub
    {4'd5, 1'b0, 32'h00400000, 32'h00400000, 32'h00800000}, // R5 to min normal
    {4'd5, 1'b1, 32'h00000001, 32'h00800000, 32'h007FFFFF}, // R5 down to subnormal
    {4'd6, 1'b0, 32'h3F800000, 32'h33800000, 32'h3F800000}, // R6 tie, even kept
    {4'd6, 1'b0, 32'h3F800001, 32'h33800000, 32'h3F800002}, // R6 tie, odd up
    {4'd6, 1'b0, 32'h3F800000, 32'h33800001, 32'h3F800001}, // R6 above half
    {4'd7, 1'b0, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000}, // R7 carry
    {4'd7, 1'b0, 32'h7F7FFFFF, 32'h73000000, 32'h7F800000}, // R7 rounding carry
    {4'd7, 1'b0, 32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000}  // R7 negative
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One operation with the output free; checks R10 latency and the value
  task automatic run_op(input logic op, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R10 no early valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check(out_valid == 1'b1, "R10 valid after two edges", {31'd0, out_valid}, 32'd1);
    check(out_result == exp, req, out_result, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_valid == 1'b0, "R9 reset out_valid", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R9 reset in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VEC[i][100:97], i);
      run_op(VEC[i][96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], tag);
    end

    // R9 back-pressure: fill both stages with out_ready low
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 1'b0; in_a = 32'h3F800000; in_b = 32'h3F800000; // 2.0
    @(posedge clk);
    @(negedge clk);
    in_a = 32'h40000000; in_b = 32'h40000000;                                 // 4.0
    check(in_ready == 1'b1, "R9 ready with output free", {31'd0, in_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R9 ready low when full", {31'd0, in_ready}, 32'd0);
    check(out_result == 32'h40000000, "R9 first result held", out_result, 32'h40000000);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R9 valid kept under stall", {31'd0, out_valid}, 32'd1);
    check(out_result == 32'h40000000, "R9 result stable under stall", out_result, 32'h40000000);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_result == 32'h40800000, "R9 second result in order", out_result, 32'h40800000);
    check(out_valid == 1'b1, "R9 second valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check(out_valid == 1'b0, "R9 drained", {31'd0, out_valid}, 32'd0);
    check(in_ready == 1'b1, "R9 ready after drain", {31'd0, in_ready}, 32'd1);

    // R1/R6 back-to-back stream with consumer always ready
    @(negedge clk);
    in_valid = 1'b1; in_op = 1'b0; in_a = 32'h3F800001; in_b = 32'h33800000;
    @(posedge clk);
    @(negedge clk);
    in_op = 1'b1; in_a = 32'h3F800000; in_b = 32'h40A00000;                 // 5-1
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_result == 32'h3F800002, "R6 streamed tie", out_result, 32'h3F800002);
    @(negedge clk);
    check(out_result == 32'h40800000, "R2 streamed rsub", out_result, 32'h40800000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule